// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital state machine that sits beside the analog front end of a single-wire LIN bus transceiver. It decides which of four operating modes the transceiver is in: unpowered, standby, normal or sleep. From that mode it drives the control lines of the analog side:

- the transmitter enable;
- the inhibit switch, which powers an external regulator;
- the bus termination select;
- the behaviour of the receive pin;
- the strength of the pull-down on the transmit pin.

Its inputs are a supply-good flag from the power-on-reset comparator, the raw enable pin and a one-cycle wakeup pulse. The wakeup pulse carries a tag that says whether it came from the local wake pin or from the bus. Wakeup detection itself happens outside the block.

The enable pin is asynchronous. It passes through a two-flop synchronizer and a filter that counts consecutive cycles at one level. Mode changes happen only after enable has held its level for a parameterised number of cycles. The first cycle count applies to going active and the second to going to sleep. Standby remembers how it was entered. After a wakeup, the receive pin is held low to signal the event. The transmit pull-down is made strong only when the wakeup was local. Both of these are released as soon as the synchronized enable goes high, without waiting for the filter.

All control pins are plain levels with no handshake. The outputs are decoded directly from the registered mode and the wakeup-flavour flags.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While reset is asserted, or in the cycle after a clock edge that samples `por_ok` low in any mode, the block is unpowered with the following outputs:
  - `tx_enable`=0 and `inh_drive`=0;
  - `term_sel`=00 (floating);
  - `rx_mode`=00 (released);
  - `txd_pd_strong`=0 (weak).
- R2: In the unpowered mode, the first edge that samples `por_ok` high enters standby with power-up flavour: `inh_drive`=1, `term_sel`=01 (resistor), `tx_enable`=0, `rx_mode`=00 and `txd_pd_strong`=0.
- R3: Normal mode is entered from standby or sleep once the synchronized enable has been high for `EN_ON_CYC` consecutive cycles. The outputs change on the (`EN_ON_CYC`+3)th edge after the enable pin rises. In normal mode the outputs are `tx_enable`=1, `inh_drive`=1, `term_sel`=01, `rx_mode`=01 (bus data) and `txd_pd_strong`=0.
- R4: An enable high run shorter than `EN_ON_CYC` cycles causes no mode change, and any opposite level restarts the count.
- R5: Normal mode moves to sleep once enable has been low for `EN_OFF_CYC` consecutive cycles, on the (`EN_OFF_CYC`+3)th edge after the fall. A shorter low run leaves normal mode unchanged. In sleep the outputs are `tx_enable`=0, `inh_drive`=0, `term_sel`=10 (current source), `rx_mode`=00 and `txd_pd_strong`=0.
- R6: A wakeup pulse in sleep enters standby at the next edge with `rx_mode`=10 (forced low). `txd_pd_strong` is 1 when `wake_local`=1 (local wake) and 0 when `wake_local`=0 (bus wake). If both apply in the same cycle, a wakeup takes priority over the enable filter.
- R7: In normal mode, a wakeup pulse while the synchronized enable is low (during the sleep filtering interval) enters standby with the wakeup flavour of R6. While the synchronized enable is high, a wakeup in normal mode is ignored.
- R8: Further wakeup pulses in standby leave `rx_mode` and `txd_pd_strong` unchanged.
- R9: In standby, both `rx_mode` and `txd_pd_strong` return to 0 on the third edge after the enable pin rises, before the filter allows normal mode.
- R10: Wakeup pulses in the unpowered mode have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply above power-on-reset level (synchronous to clk) |
| en_pin | input | 1 | Raw enable pin, asynchronous |
| wake_pulse | input | 1 | One-cycle wakeup event |
| wake_local | input | 1 | Wakeup type tag: 1 local pin, 0 bus |
| tx_enable | output | 1 | Bus transmitter enable |
| inh_drive | output | 1 | Inhibit switch on (regulator powered) |
| term_sel | output | 2 | Termination: 00 floating, 01 resistor, 10 current source |
| rx_mode | output | 2 | Receive pin: 00 released, 01 bus data, 10 forced low |
| txd_pd_strong | output | 1 | Transmit pin pull-down: 1 strong, 0 weak |

## Verification
The assertions assume the following about the inputs:
- `wake_pulse` and `wake_local` are synchronous to `clk`, and the tag is valid whenever the pulse is high;
- `por_ok` is already synchronized.

The properties relate each mode change to the filter outcome or the event sampled one edge earlier, so they hold only when those inputs are clean. The stimulus meets these assumptions by driving every input at the falling clock edge and holding each wakeup pulse for exactly one cycle. Enable runs are swept across lengths just below, at and just above both filter thresholds, using small threshold values.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    MS_OFF   = 2'd0,
    MS_STBY  = 2'd1,
    MS_NORM  = 2'd2,
    MS_SLEEP = 2'd3
  } mode_e;

  localparam logic [1:0] TERM_FLOAT = 2'b00;
  localparam logic [1:0] TERM_RES   = 2'b01;
  localparam logic [1:0] TERM_CSRC  = 2'b10;

  localparam logic [1:0] RX_REL  = 2'b00;
  localparam logic [1:0] RX_DATA = 2'b01;
  localparam logic [1:0] RX_LOW  = 2'b10;
endpackage

// File: rtl/lin_en_sync.sv
module lin_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh[i] <= 1'b0;
        else        sh[i] <= sh[i-1];
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/lin_en_filter.sv
module lin_en_filter #(
  parameter int ON_CYC  = 100,
  parameter int OFF_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  output logic hi_done,
  output logic lo_done
);
  localparam int MAXC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          lvl;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b0;
      run <= '0;
    end else if (en_s != lvl) begin
      lvl <= en_s;
      run <= CW'(1);
    end else if (run != CW'(MAXC)) begin
      run <= run + CW'(1);
    end
  end

  assign hi_done = lvl  && (run >= CW'(ON_CYC));
  assign lo_done = !lvl && (run >= CW'(OFF_CYC));
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       en_s,
  input  logic       hi_done,
  input  logic       lo_done,
  input  logic       wake_pulse,
  input  logic       wake_local,
  output logic       tx_enable,
  output logic       inh_drive,
  output logic [1:0] term_sel,
  output logic [1:0] rx_mode,
  output logic       txd_pd_strong
);
  mode_e mode_q, mode_d;
  logic  rxlow_q, rxlow_d;
  logic  pdstr_q, pdstr_d;

  always_comb begin
    mode_d  = mode_q;
    rxlow_d = rxlow_q;
    pdstr_d = pdstr_q;
    if (!por_ok) begin
      mode_d  = MS_OFF;
      rxlow_d = 1'b0;
      pdstr_d = 1'b0;
    end else begin
      unique case (mode_q)
        MS_OFF: begin
          mode_d  = MS_STBY;
          rxlow_d = 1'b0;
          pdstr_d = 1'b0;
        end
        MS_STBY: begin
          if (hi_done) begin
            mode_d  = MS_NORM;
            rxlow_d = 1'b0;
            pdstr_d = 1'b0;
          end else if (en_s) begin
            rxlow_d = 1'b0;
            pdstr_d = 1'b0;
          end
        end
        MS_NORM: begin
          if (wake_pulse && !en_s) begin
            mode_d  = MS_STBY;
            rxlow_d = 1'b1;
            pdstr_d = wake_local;
          end else if (lo_done) begin
            mode_d = MS_SLEEP;
          end
        end
        MS_SLEEP: begin
          if (wake_pulse) begin
            mode_d  = MS_STBY;
            rxlow_d = 1'b1;
            pdstr_d = wake_local;
          end else if (hi_done) begin
            mode_d  = MS_NORM;
            rxlow_d = 1'b0;
            pdstr_d = 1'b0;
          end
        end
        default: mode_d = MS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MS_OFF;
      rxlow_q <= 1'b0;
      pdstr_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      rxlow_q <= rxlow_d;
      pdstr_q <= pdstr_d;
    end
  end

  always_comb begin
    tx_enable     = 1'b0;
    inh_drive     = 1'b0;
    term_sel      = TERM_FLOAT;
    rx_mode       = RX_REL;
    txd_pd_strong = 1'b0;
    unique case (mode_q)
      MS_STBY: begin
        inh_drive     = 1'b1;
        term_sel      = TERM_RES;
        rx_mode       = rxlow_q ? RX_LOW : RX_REL;
        txd_pd_strong = pdstr_q;
      end
      MS_NORM: begin
        tx_enable = 1'b1;
        inh_drive = 1'b1;
        term_sel  = TERM_RES;
        rx_mode   = RX_DATA;
      end
      MS_SLEEP: term_sel = TERM_CSRC;
      default: ;
    endcase
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl #(
  parameter int CLK_MHZ     = 20,
  parameter int SYNC_STAGES = 2,
  parameter int EN_ON_CYC   = 5 * CLK_MHZ,
  parameter int EN_OFF_CYC  = 5 * CLK_MHZ
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       en_pin,
  input  logic       wake_pulse,
  input  logic       wake_local,
  output logic       tx_enable,
  output logic       inh_drive,
  output logic [1:0] term_sel,
  output logic [1:0] rx_mode,
  output logic       txd_pd_strong
);
  logic en_s;
  logic hi_done;
  logic lo_done;

  lin_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(en_pin), .q(en_s)
  );

  lin_en_filter #(.ON_CYC(EN_ON_CYC), .OFF_CYC(EN_OFF_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .hi_done(hi_done), .lo_done(lo_done)
  );

  lin_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_s(en_s),
    .hi_done(hi_done), .lo_done(lo_done),
    .wake_pulse(wake_pulse), .wake_local(wake_local),
    .tx_enable(tx_enable), .inh_drive(inh_drive), .term_sel(term_sel),
    .rx_mode(rx_mode), .txd_pd_strong(txd_pd_strong)
  );
endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_ok,
  input logic       wake_pulse,
  input logic       wake_local,
  input logic       en_s,
  input logic       hi_done,
  input logic       lo_done,
  input logic       tx_enable,
  input logic       inh_drive,
  input logic [1:0] term_sel,
  input logic [1:0] rx_mode,
  input logic       txd_pd_strong
);
  // R1: supply loss forces the unpowered outputs at the next edge
  a_r1_por_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> (!tx_enable && !inh_drive && term_sel == 2'b00));

  // R3: transmitter turns on only after the enable filter completed
  a_r3_norm_after_filter: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_enable) |-> $past(hi_done));

  // R5: transmitter turns off only after a disable filter, wakeup or supply loss
  a_r5_leave_norm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_enable) |-> $past(lo_done || wake_pulse || !por_ok));

  // R6: strong pull-down appears only after a local wakeup
  a_r6_strong_after_local: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txd_pd_strong) |-> $past(wake_pulse && wake_local));

  // R8: wakeup inside standby keeps the pin configuration
  a_r8_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_drive && !tx_enable && por_ok && wake_pulse && !en_s && !hi_done)
    |=> (txd_pd_strong == $past(txd_pd_strong) && rx_mode == $past(rx_mode)));
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .wake_pulse(wake_pulse),
  .wake_local(wake_local), .en_s(en_s), .hi_done(hi_done), .lo_done(lo_done),
  .tx_enable(tx_enable), .inh_drive(inh_drive), .term_sel(term_sel),
  .rx_mode(rx_mode), .txd_pd_strong(txd_pd_strong)
);

// File: tb/lin_mode_ctrl_bench.sv
module lin_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_ON  = 4;
  localparam int T_OFF = 6;

  // packed view: {tx, inh, term[1:0], rx[1:0], pd}
  localparam logic [6:0] UNP     = 7'b0000000;
  localparam logic [6:0] STB_PU  = 7'b0101000;
  localparam logic [6:0] STB_LOC = 7'b0101101;
  localparam logic [6:0] STB_BUS = 7'b0101100;
  localparam logic [6:0] NORM    = 7'b1101010;
  localparam logic [6:0] SLP     = 7'b0010000;

  logic clk = 1'b0;
  logic rst_n, por_ok, en_pin, wake_pulse, wake_local;
  logic tx_enable, inh_drive, txd_pd_strong;
  logic [1:0] term_sel, rx_mode;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_mode_ctrl #(.EN_ON_CYC(T_ON), .EN_OFF_CYC(T_OFF)) u_lin_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_pin(en_pin),
    .wake_pulse(wake_pulse), .wake_local(wake_local),
    .tx_enable(tx_enable), .inh_drive(inh_drive), .term_sel(term_sel),
    .rx_mode(rx_mode), .txd_pd_strong(txd_pd_strong)
  );

  wire [6:0] outs = {tx_enable, inh_drive, term_sel, rx_mode, txd_pd_strong};

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [6:0] exp);
    checks++;
    if (outs !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, outs, exp, $time);
    end
  endtask

  task automatic wake(input logic loc);
    wake_local = loc;
    wake_pulse = 1'b1;
    step(1);
    wake_pulse = 1'b0;
    wake_local = 1'b0;
  endtask

  task automatic repower();
    por_ok = 1'b0;
    step(1);
    chk("R1", UNP);
    por_ok = 1'b1;
    step(1);
    chk("R2", STB_PU);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; por_ok = 1'b0; en_pin = 1'b0;
    wake_pulse = 1'b0; wake_local = 1'b0;
    step(2);
    chk("R1", UNP);
    rst_n = 1'b1;
    step(2);
    chk("R1", UNP);
    wake(1'b1);
    chk("R10", UNP);
    wake(1'b0);
    chk("R10", UNP);
    por_ok = 1'b1;
    step(1);
    chk("R2", STB_PU);

    // R4 / R3 sweep of enable high run lengths
    for (int len = 1; len <= T_ON + 2; len++) begin
      en_pin = 1'b1;
      step(len);
      en_pin = 1'b0;
      step(3);
      chk(len >= T_ON ? "R3" : "R4", len >= T_ON ? NORM : STB_PU);
      if (len >= T_ON) repower();
      step(2);
    end

    // R3 exact edge
    en_pin = 1'b1;
    step(T_ON + 2);
    chk("R3", STB_PU);
    step(1);
    chk("R3", NORM);

    // R5 sweep of enable low run lengths, then back to normal from sleep
    for (int len = 1; len <= T_OFF + 1; len++) begin
      en_pin = 1'b0;
      step(len);
      en_pin = 1'b1;
      step(3);
      chk("R5", len >= T_OFF ? SLP : NORM);
      step(T_ON);
      chk("R3", NORM);
    end

    // R6 local wake from sleep, R8 hold, R9 early release
    en_pin = 1'b0;
    step(T_OFF + 3);
    chk("R5", SLP);
    wake(1'b1);
    chk("R6", STB_LOC);
    wake(1'b0);
    chk("R8", STB_LOC);
    wake(1'b1);
    chk("R8", STB_LOC);
    en_pin = 1'b1;
    step(2);
    chk("R9", STB_LOC);
    step(1);
    chk("R9", STB_PU);
    step(T_ON);
    chk("R3", NORM);

    // R6 bus wake from sleep, R8 hold
    en_pin = 1'b0;
    step(T_OFF + 3);
    chk("R5", SLP);
    wake(1'b0);
    chk("R6", STB_BUS);
    wake(1'b1);
    chk("R8", STB_BUS);

    // R7 wake during disable filtering, and ignored while enabled
    en_pin = 1'b1;
    step(T_ON + 3);
    chk("R3", NORM);
    en_pin = 1'b0;
    step(2);
    wake(1'b1);
    chk("R7", STB_LOC);
    en_pin = 1'b1;
    step(T_ON + 3);
    chk("R3", NORM);
    wake(1'b1);
    chk("R7", NORM);
    wake(1'b0);
    chk("R7", NORM);

    // R1 supply loss from normal
    por_ok = 1'b0;
    step(1);
    chk("R1", UNP);
    en_pin = 1'b0;
    por_ok = 1'b1;
    step(1);
    chk("R2", STB_PU);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule